// File: doc/BRIEF.md
# Quarter-Pel Interpolation Filter

This block computes fractional-position pixels for an 8x8 block, working along one dimension at a time. A 2-bit mode picks the fractional offset: a quarter, a half or three quarters of a pixel. Every output pixel is a weighted sum of four consecutive source pixels along the filtering direction. The sum is rounded, shifted down, clamped to 8 bits and then either passed out as it is or averaged with the pixel already in the destination.

The caller sends the source as a stream of lines. For horizontal filtering a line is a row; for vertical filtering a line is a column. Each line carries the eight samples on the line plus the border samples the taps need: one before and two after, eleven samples in all. The destination pixel for averaging travels on a side lane beside the source sample that completes each four-sample window. Results leave as a stream with a valid/ready handshake, one per cycle once the pipeline is full, and the 64th result of a block is flagged as the last.

The mode, direction, rounding bit and averaging switch are taken at the first sample of a block and hold for the whole block.

Top module: `qpel_interp`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Mode 1 (quarter offset) weights the four window samples, oldest first, by -4, 53, 18 and -3. It adds (32 - r) and shifts arithmetically right by 6, where r is the effective rounding bit.
- R3: Mode 3 (three-quarter offset) uses the mirrored weights -3, 18, 53 and -4, oldest first, with the same (32 - r) rounder and right shift by 6.
- R4: Mode 2 (half offset) weights the four window samples by -1, 9, 9 and -1. It adds (8 - r) and shifts arithmetically right by 4.
- R5: A filtered value below 0 becomes 0, and a value above 255 becomes 255.
- R6: With `cfg_vert`=1 the effective rounding bit r is (1 - `cfg_rnd`). With `cfg_vert`=0 it is `cfg_rnd`.
- R7: With `cfg_avg`=1 the output is (f + d + 1) >> 1, where f is the filtered value and d is `in_dst`. With `cfg_avg`=0 the output is f, and `in_dst` has no effect on it.
- R8: A block is 8 lines of 11 samples. The first three samples of each line produce no output, and every later sample produces one output, so a block gives 64 outputs in stream order. `out_last` is 1 on the 64th output only.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_pix` and `out_last` hold steady. No result is lost or repeated.
- R10: The configuration inputs are captured at the first sample of a block. Changes to them later in the same block have no effect.
- R11: With `out_ready` held at 1, the output for a sample accepted at clock edge k is presented after edge k+1, and results can follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Offset: 1 quarter, 2 half, 3 three-quarter (0 behaves as half) |
| cfg_vert | input | 1 | 1 when the lines are columns (vertical filtering) |
| cfg_rnd | input | 1 | Rounding control bit |
| cfg_avg | input | 1 | 1 to average with the destination pixel |
| in_valid | input | 1 | Source sample valid |
| in_ready | output | 1 | Block accepts a sample |
| in_pix | input | 8 | Source sample |
| in_dst | input | 8 | Destination pixel for the output this sample completes |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_pix | output | 8 | Interpolated pixel |
| out_last | output | 1 | Marks the 64th result of a block |

## Verification
A sample that completes a window is registered as a window at its accepting edge. The result is registered at the next edge, so with no backpressure it is due one edge after acceptance. The driver records the cycle of each accepted window sample together with the expected value. In runs without backpressure, the monitor requires every result to appear exactly one cycle after the recorded cycle. In runs where `out_ready` is toggled, the monitor checks only the order and values of results as each is taken, because the due cycle then depends on the stalls.

// File: rtl/qpel_pkg.sv
package qpel_pkg;

  localparam int QP_TAPS        = 4;
  localparam int QP_COEF_W      = 8;
  localparam int QP_SHIFT_HALF  = 4;
  localparam int QP_SHIFT_CUBIC = 6;
  localparam int QP_BIAS_HALF   = 8;
  localparam int QP_BIAS_CUBIC  = 32;

  typedef enum logic [1:0] {
    QP_COPY    = 2'd0,
    QP_QUARTER = 2'd1,
    QP_HALF    = 2'd2,
    QP_THREEQ  = 2'd3
  } qp_mode_e;

  typedef struct packed {
    qp_mode_e mode;
    logic     vert;
    logic     rnd;
    logic     avg;
  } qp_cfg_t;

  // weight of tap idx (0 = oldest sample of the window)
  function automatic logic signed [QP_COEF_W-1:0] qp_coef(qp_mode_e m, int idx);
    logic signed [QP_COEF_W-1:0] c;
    case (m)
      QP_QUARTER: begin
        case (idx)
          0:       c = -8'sd4;
          1:       c = 8'sd53;
          2:       c = 8'sd18;
          default: c = -8'sd3;
        endcase
      end
      QP_THREEQ: begin
        case (idx)
          0:       c = -8'sd3;
          1:       c = 8'sd18;
          2:       c = 8'sd53;
          default: c = -8'sd4;
        endcase
      end
      default: begin
        case (idx)
          0:       c = -8'sd1;
          1:       c = 8'sd9;
          2:       c = 8'sd9;
          default: c = -8'sd1;
        endcase
      end
    endcase
    return c;
  endfunction

  function automatic logic qp_is_bicubic(qp_mode_e m);
    return (m == QP_QUARTER) || (m == QP_THREEQ);
  endfunction

endpackage

// File: rtl/qpel_window.sv
module qpel_window
  import qpel_pkg::*;
#(
  parameter int PIX_W        = 8,
  parameter int OUT_PER_LINE = 8,
  parameter int LINES        = 8,
  parameter int TAPS         = QP_TAPS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  input  logic                        in_valid,
  input  logic [PIX_W-1:0]            in_pix,
  input  logic [PIX_W-1:0]            in_dst,
  input  qp_cfg_t                     cfg_in,
  output logic                        win_valid,
  output logic [TAPS-1:0][PIX_W-1:0]  win_pix,
  output logic [PIX_W-1:0]            win_dst,
  output logic                        win_last,
  output qp_cfg_t                     win_cfg
);

  localparam int LINE_LEN = OUT_PER_LINE + TAPS - 1;
  localparam int POS_W    = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam int LINE_W   = (LINES > 1) ? $clog2(LINES) : 1;

  logic [POS_W-1:0]                pos;
  logic [LINE_W-1:0]               line;
  logic [TAPS-2:0][PIX_W-1:0]      hist;
  qp_cfg_t                         cfg_q;
  logic                            take;
  logic                            first_beat;
  logic                            line_end;

  assign take       = adv && in_valid;
  assign first_beat = (pos == '0) && (line == '0);
  assign line_end   = (pos == POS_W'(LINE_LEN - 1));

  // position counters within the block
  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      line <= '0;
    end else if (take) begin
      if (line_end) begin
        pos  <= '0;
        line <= (line == LINE_W'(LINES - 1)) ? '0 : line + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  // sample history, newest at index 0
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (take) begin
      hist[0] <= in_pix;
      for (int i = 1; i < TAPS - 1; i++) hist[i] <= hist[i-1];
    end
  end

  // configuration held for the whole block
  always_ff @(posedge clk) begin
    if (rst)                      cfg_q <= '0;
    else if (take && first_beat)  cfg_q <= cfg_in;
  end

  // window register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_last  <= 1'b0;
      win_dst   <= '0;
      win_cfg   <= '0;
    end else if (adv) begin
      win_valid <= take && (pos >= POS_W'(TAPS - 1));
      if (take) begin
        win_last <= line_end && (line == LINE_W'(LINES - 1));
        win_dst  <= in_dst;
        win_cfg  <= cfg_q;
      end
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win_pix[k] <= '0;
      end else if (take) begin
        if (k == TAPS - 1) win_pix[k] <= in_pix;
        else               win_pix[k] <= hist[TAPS-2-k];
      end
    end
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    !(take && first_beat) |=> $stable(cfg_q)); // R10

  AST_WIN_NEEDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    $rose(win_valid) |-> $past(in_valid)); // R8

endmodule

// File: rtl/qpel_tap_filter.sv
module qpel_tap_filter
  import qpel_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int TAPS  = QP_TAPS,
  parameter int SUM_W = 16
) (
  input  logic [TAPS-1:0][PIX_W-1:0] win_pix,
  input  qp_mode_e                   mode,
  input  logic                       vert,
  input  logic                       rnd,
  output logic [PIX_W-1:0]           filt
);

  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic signed [QP_COEF_W-1:0] coef     [TAPS];
  logic signed [SUM_W-1:0]     pix_ext  [TAPS];
  logic signed [SUM_W-1:0]     coef_ext [TAPS];
  logic signed [SUM_W-1:0]     prod     [TAPS];
  logic signed [SUM_W-1:0]     acc;
  logic signed [SUM_W-1:0]     bias;
  logic signed [SUM_W-1:0]     biased;
  logic signed [SUM_W-1:0]     shifted;
  logic                        eff_rnd;
  logic                        cubic;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign coef[k]     = qp_coef(mode, k);
    assign pix_ext[k]  = {{(SUM_W-PIX_W){1'b0}}, win_pix[k]};
    assign coef_ext[k] = {{(SUM_W-QP_COEF_W){coef[k][QP_COEF_W-1]}}, coef[k]};
    assign prod[k]     = pix_ext[k] * coef_ext[k];
  end

  assign eff_rnd = vert ? ~rnd : rnd;
  assign cubic   = qp_is_bicubic(mode);

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
  end

  assign bias   = (cubic ? SUM_W'(QP_BIAS_CUBIC) : SUM_W'(QP_BIAS_HALF)) - SUM_W'(eff_rnd);
  assign biased = acc + bias;

  always_comb begin
    if (cubic) shifted = biased >>> QP_SHIFT_CUBIC;
    else       shifted = biased >>> QP_SHIFT_HALF;
  end

  always_comb begin
    if (shifted[SUM_W-1])        filt = '0;
    else if (shifted > PIX_MAX)  filt = '1;
    else                         filt = shifted[PIX_W-1:0];
  end

endmodule

// File: rtl/qpel_blend.sv
module qpel_blend #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] filt,
  input  logic [PIX_W-1:0] dst,
  input  logic             avg,
  output logic [PIX_W-1:0] blended
);

  logic [PIX_W:0] total;

  assign total   = {1'b0, filt} + {1'b0, dst} + (PIX_W+1)'(1);
  assign blended = avg ? total[PIX_W:1] : filt;

endmodule

// File: rtl/qpel_interp.sv
module qpel_interp
  import qpel_pkg::*;
#(
  parameter int PIX_W        = 8,
  parameter int OUT_PER_LINE = 8,
  parameter int LINES        = 8,
  parameter int SUM_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_vert,
  input  logic             cfg_rnd,
  input  logic             cfg_avg,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [PIX_W-1:0] in_dst,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_last
);

  localparam int BLOCK_OUT = OUT_PER_LINE * LINES;
  localparam int OCNT_W    = (BLOCK_OUT > 1) ? $clog2(BLOCK_OUT) : 1;

  logic                             adv;
  qp_cfg_t                          cfg_in;
  logic                             win_valid;
  logic [QP_TAPS-1:0][PIX_W-1:0]    win_pix;
  logic [PIX_W-1:0]                 win_dst;
  logic                             win_last;
  qp_cfg_t                          win_cfg;
  logic [PIX_W-1:0]                 filt;
  logic [PIX_W-1:0]                 blended;
  logic [OCNT_W-1:0]                ocnt;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign cfg_in.mode = qp_mode_e'(cfg_mode);
  assign cfg_in.vert = cfg_vert;
  assign cfg_in.rnd  = cfg_rnd;
  assign cfg_in.avg  = cfg_avg;

  qpel_window #(
    .PIX_W        (PIX_W),
    .OUT_PER_LINE (OUT_PER_LINE),
    .LINES        (LINES),
    .TAPS         (QP_TAPS)
  ) u_window (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .in_dst    (in_dst),
    .cfg_in    (cfg_in),
    .win_valid (win_valid),
    .win_pix   (win_pix),
    .win_dst   (win_dst),
    .win_last  (win_last),
    .win_cfg   (win_cfg)
  );

  qpel_tap_filter #(
    .PIX_W (PIX_W),
    .TAPS  (QP_TAPS),
    .SUM_W (SUM_W)
  ) u_filter (
    .win_pix (win_pix),
    .mode    (win_cfg.mode),
    .vert    (win_cfg.vert),
    .rnd     (win_cfg.rnd),
    .filt    (filt)
  );

  qpel_blend #(
    .PIX_W (PIX_W)
  ) u_blend (
    .filt    (filt),
    .dst     (win_dst),
    .avg     (win_cfg.avg),
    .blended (blended)
  );

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_last  <= 1'b0;
    end else if (adv) begin
      out_valid <= win_valid;
      if (win_valid) begin
        out_pix  <= blended;
        out_last <= win_last;
      end
    end
  end

  // count of results taken within the current block
  always_ff @(posedge clk) begin
    if (rst) begin
      ocnt <= '0;
    end else if (out_valid && out_ready) begin
      ocnt <= (ocnt == OCNT_W'(BLOCK_OUT - 1)) ? '0 : ocnt + 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_last)); // R9

  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> ocnt == OCNT_W'(BLOCK_OUT - 1)); // R8

  AST_AVG_RANGE: assert property (@(posedge clk) disable iff (rst)
    win_valid && win_cfg.avg |->
      ((blended >= filt && blended <= win_dst) || (blended <= filt && blended >= win_dst))); // R7

  AST_PUT_PASS: assert property (@(posedge clk) disable iff (rst)
    win_valid && !win_cfg.avg |-> blended == filt); // R7

  AST_RESULT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(win_valid)); // R11

endmodule

// File: tb/qpel_interp_tb.sv
module qpel_interp_tb;

  typedef struct {
    int    pix;
    bit    last;
    int    cyc;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'd1;
  logic       cfg_vert = 1'b0;
  logic       cfg_rnd = 1'b0;
  logic       cfg_avg = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_pix = '0;
  logic [7:0] in_dst = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_pix;
  logic       out_last;

  int   checks = 0;
  int   errors = 0;
  int   cycnt  = 0;
  bit   lat_chk = 1'b0;
  bit   done_flag = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  exp_t sbq[$];

  always #2 clk = ~clk;

  always @(posedge clk) cycnt <= cycnt + 1;

  qpel_interp u_dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_mode  (cfg_mode),
    .cfg_vert  (cfg_vert),
    .cfg_rnd   (cfg_rnd),
    .cfg_avg   (cfg_avg),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pix    (in_pix),
    .in_dst    (in_dst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .out_last  (out_last)
  );

  function automatic int model(int a, int b, int c, int d, int mode, int vert,
                               int rnd, int avg, int dst);
    int s;
    int r;
    r = vert ? 1 - rnd : rnd;
    if (mode == 1) begin
      s = -4*a + 53*b + 18*c - 3*d;
      s = (s + 32 - r) >>> 6;
    end else if (mode == 3) begin
      s = -3*a + 18*b + 53*c - 4*d;
      s = (s + 32 - r) >>> 6;
    end else begin
      s = -a + 9*b + 9*c - d;
      s = (s + 8 - r) >>> 4;
    end
    if (s < 0)   s = 0;
    if (s > 255) s = 255;
    if (avg != 0) s = (s + dst + 1) >> 1;
    return s;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int gen_pix(int kind, int line, int p);
    case (kind)
      1:       return ((p % 4) == 1 || (p % 4) == 2) ? 255 : 0;
      2:       return ((p % 3) == 0) ? 255 : 0;
      3:       return (line * 29 + p * 17) % 256;
      default: return $urandom_range(0, 255);
    endcase
  endfunction

  task automatic run_block(int mode, int vert, int rnd, int avg, int kind,
                           bit stall, bit scramble, string tag);
    int row[11];
    lat_chk = !stall;
    for (int line = 0; line < 8; line++) begin
      for (int p = 0; p < 11; p++) begin
        bit   acc;
        int   dst;
        exp_t e;
        row[p] = gen_pix(kind, line, p);
        dst    = $urandom_range(0, 255);
        acc    = 1'b0;
        while (!acc) begin
          @(negedge clk);
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          out_ready = stall ? lfsr[0] : 1'b1;
          if (scramble && !(line == 0 && p == 0)) begin
            cfg_mode = 2'($urandom_range(0, 3));
            cfg_vert = 1'($urandom_range(0, 1));
            cfg_rnd  = 1'($urandom_range(0, 1));
            cfg_avg  = 1'($urandom_range(0, 1));
          end else begin
            cfg_mode = 2'(mode);
            cfg_vert = 1'(vert);
            cfg_rnd  = 1'(rnd);
            cfg_avg  = 1'(avg);
          end
          in_valid = 1'b1;
          in_pix   = 8'(row[p]);
          in_dst   = 8'(dst);
          #1;
          acc = in_ready;
          @(posedge clk);
          #1;
        end
        if (p >= 3) begin
          e.pix  = model(row[p-3], row[p-2], row[p-1], row[p], mode, vert, rnd, avg, dst);
          e.last = (line == 7 && p == 10);
          e.cyc  = cycnt;
          e.tag  = tag;
          sbq.push_back(e);
        end
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    while (sbq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (!rst && out_valid && out_ready) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8", "unexpected result", int'(out_pix), -1);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(int'(out_pix) == e.pix, e.tag, "pixel", int'(out_pix), e.pix);
        check(out_last == e.last, "R8", "last flag", int'(out_last), int'(e.last));
        if (lat_chk)
          check(cycnt == e.cyc + 1, "R11", "result cycle", cycnt, e.cyc + 1);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycnt, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    run_block(1, 0, 0, 0, 0, 1'b0, 1'b0, "R2");
    run_block(1, 0, 1, 0, 3, 1'b0, 1'b0, "R2");
    run_block(3, 0, 0, 0, 0, 1'b0, 1'b0, "R3");
    run_block(3, 0, 1, 0, 3, 1'b0, 1'b0, "R3");
    run_block(2, 0, 0, 0, 0, 1'b0, 1'b0, "R4");
    run_block(2, 0, 1, 0, 3, 1'b0, 1'b0, "R4");
    run_block(1, 0, 0, 0, 1, 1'b0, 1'b0, "R5");
    run_block(3, 0, 1, 0, 2, 1'b0, 1'b0, "R5");
    run_block(2, 0, 0, 0, 2, 1'b0, 1'b0, "R5");
    run_block(2, 1, 0, 0, 0, 1'b0, 1'b0, "R6");
    run_block(1, 1, 1, 0, 0, 1'b0, 1'b0, "R6");
    run_block(3, 1, 0, 0, 3, 1'b0, 1'b0, "R6");
    run_block(1, 0, 0, 1, 0, 1'b0, 1'b0, "R7");
    run_block(2, 1, 1, 1, 1, 1'b0, 1'b0, "R7");
    run_block(3, 0, 0, 1, 0, 1'b1, 1'b0, "R9");
    run_block(2, 1, 0, 0, 0, 1'b1, 1'b0, "R9");
    run_block(1, 0, 1, 0, 0, 1'b0, 1'b1, "R10");
    run_block(3, 1, 1, 1, 0, 1'b1, 1'b1, "R10");

    check(sbq.size() == 0, "R9", "results outstanding", sbq.size(), 0);
    finish_run();
  end

endmodule